// File: doc/BRIEF.md
# UART Baud Tick Generator

This block derives the timing strobes that a UART transmitter and receiver need from a fast reference clock. The ratio is set in two stages. A coarse prescaler divides the reference clock by a small ratio. A fine divisor then divides the prescaled rate down to the oversampling rate. Both ratios sit in one 32-bit control word that software writes through a simple write strobe and can read back.

The block produces two strobes. The oversampling tick is a single-cycle strobe. The bit strobe marks the end of each serial bit, and one serial bit lasts thirteen oversampling ticks. A divisor that has just been written does not disturb a bit already in progress. It is held pending and takes effect at the next bit boundary. A busy flag stays high for the whole time a written setting is waiting, so software can poll it before writing again.

Top module: `baud_tick_gen`

## Requirements
- R1: A synchronous active-high reset clears the control word (read back as 0) and clears busy. Both ratios then divide by one, so `os_tick` is high on every cycle after reset is released.
- R2: The control word holds the prescaler field, the ratio minus one, in bits 19:16, and the fine divisor field, the value minus one, in bits 9:0. `rd_data` shows the last written word with every other bit forced to zero, from the cycle after the write.
- R3: With prescaler field P and divisor field D in effect, rising `os_tick` pulses are exactly (P+1)*(D+1) cycles apart. Each pulse lasts one cycle unless P and D are both 0.
- R4: `bit_tick` is high only together with `os_tick`, on every thirteenth `os_tick`. Its pulses are therefore 13*(P+1)*(D+1) cycles apart. After reset the first `bit_tick` comes on the thirteenth cycle.
- R5: `busy` is high in the cycle after any write.
- R6: A written setting stays pending, with the old spacing unchanged, until the next `bit_tick`. `busy` falls in the same cycle as that `bit_tick`, and the spacing measured from that tick onward follows the new setting.
- R7: A second write while a setting is still pending replaces it. Only the latest word takes effect at the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word read back, unused bits zero |
| busy | output | 1 | A written setting is waiting for a bit boundary |
| os_tick | output | 1 | Oversampling strobe |
| bit_tick | output | 1 | Bit-period strobe, every thirteenth oversampling strobe |

## Verification
The hardest case to reach is a setting that stays pending across several oversampling ticks and then replaces another pending setting before any boundary has passed. To get there, the stimulus writes twice in quick succession right after a measured bit strobe, which leaves a whole slow bit period before the next boundary. While waiting, the bench checks that the old spacing is kept. It then confirms that busy falls together with a bit strobe and that only the second word sets the new spacing. The stimulus also steps through the extreme settings: divide by one in both stages, the largest prescale, and the largest fine divisor.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int CTRL_W_DEF     = 32;
  localparam int PRE_W_DEF      = 4;
  localparam int PRE_LSB_DEF    = 16;
  localparam int DIV_W_DEF      = 10;
  localparam int DIV_LSB_DEF    = 0;
  localparam int OS_PER_BIT_DEF = 13;

  typedef enum logic {
    CFG_IDLE    = 1'b0,
    CFG_PENDING = 1'b1
  } cfg_state_e;

  // Mask of the implemented bits within the control word.
  function automatic logic [63:0] field_mask(input int pre_lsb, input int pre_w,
                                             input int div_lsb, input int div_w);
    logic [63:0] m;
    m = (((64'd1 << pre_w) - 64'd1) << pre_lsb) |
        (((64'd1 << div_w) - 64'd1) << div_lsb);
    return m;
  endfunction

endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg #(
  parameter int CTRL_W  = baud_pkg::CTRL_W_DEF,
  parameter int PRE_W   = baud_pkg::PRE_W_DEF,
  parameter int PRE_LSB = baud_pkg::PRE_LSB_DEF,
  parameter int DIV_W   = baud_pkg::DIV_W_DEF,
  parameter int DIV_LSB = baud_pkg::DIV_LSB_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              boundary,
  output logic [PRE_W-1:0]  act_pre,
  output logic [DIV_W-1:0]  act_div,
  output logic              busy,
  output logic [CTRL_W-1:0] rd_data
);
  import baud_pkg::*;

  localparam logic [CTRL_W-1:0] MASK =
    CTRL_W'(field_mask(PRE_LSB, PRE_W, DIV_LSB, DIV_W));

  cfg_state_e        state;
  logic [PRE_W-1:0]  pend_pre;
  logic [DIV_W-1:0]  pend_div;
  logic              load;

  assign load = (state == CFG_PENDING) && boundary;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CFG_IDLE;
      pend_pre <= '0;
      pend_div <= '0;
      act_pre  <= '0;
      act_div  <= '0;
      rd_data  <= '0;
    end else begin
      if (load) begin
        act_pre <= pend_pre;
        act_div <= pend_div;
      end
      if (wr_en) begin
        pend_pre <= wr_data[PRE_LSB +: PRE_W];
        pend_div <= wr_data[DIV_LSB +: DIV_W];
        rd_data  <= wr_data & MASK;
        state    <= CFG_PENDING;
      end else if (load) begin
        state    <= CFG_IDLE;
      end
    end
  end

  assign busy = (state == CFG_PENDING);

  // R5
  a_r5_busy_after_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> busy);

  // R2
  a_r2_readback: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == ($past(wr_data) & MASK));

  // R6: the live setting holds until a boundary
  a_r6_hold_until_boundary: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(act_pre) && $stable(act_div));

  // R6: pending clears at the boundary when no new write arrives
  a_r6_clear_at_boundary: assert property (@(posedge clk) disable iff (rst)
    busy && boundary && !wr_en |=> !busy);

endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int PRE_W = baud_pkg::PRE_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] ratio_m1,
  output logic             fire
);
  logic [PRE_W-1:0] cnt;

  assign fire = (cnt == ratio_m1);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (fire) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R3: the coarse count never runs past the programmed ratio
  a_r3_pre_in_range: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> cnt <= ratio_m1);

endmodule

// File: rtl/baud_fine_div.sv
module baud_fine_div #(
  parameter int DIV_W = baud_pkg::DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [DIV_W-1:0] div_m1,
  output logic             os_fire,
  output logic             os_tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap    = (cnt == div_m1);
  assign os_fire = step && wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      os_tick <= 1'b0;
    end else begin
      os_tick <= os_fire;
      if (step) begin
        if (wrap) cnt <= '0;
        else      cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: with a divisor above one, a tick is never followed at once by another
  a_r3_os_single_pulse: assert property (@(posedge clk) disable iff (rst)
    os_tick && (div_m1 != '0) |=> !os_tick || (div_m1 != $past(div_m1)));

endmodule

// File: rtl/baud_bit_count.sv
module baud_bit_count #(
  parameter int OS_PER_BIT = baud_pkg::OS_PER_BIT_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic os_fire,
  output logic bit_fire,
  output logic bit_tick
);
  localparam int BCNT_W = (OS_PER_BIT > 1) ? $clog2(OS_PER_BIT) : 1;

  generate
    if (OS_PER_BIT > 1) begin : g_count
      logic [BCNT_W-1:0] bcnt;
      logic              last;

      assign last     = (bcnt == BCNT_W'(OS_PER_BIT - 1));
      assign bit_fire = os_fire && last;

      always_ff @(posedge clk) begin
        if (rst) begin
          bcnt <= '0;
        end else if (os_fire) begin
          if (last) bcnt <= '0;
          else      bcnt <= bcnt + 1'b1;
        end
      end

      // R4
      a_r4_count_range: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> bcnt < BCNT_W'(OS_PER_BIT));
    end else begin : g_direct
      assign bit_fire = os_fire;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) bit_tick <= 1'b0;
    else     bit_tick <= bit_fire;
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int CTRL_W     = baud_pkg::CTRL_W_DEF,
  parameter int PRE_W      = baud_pkg::PRE_W_DEF,
  parameter int PRE_LSB    = baud_pkg::PRE_LSB_DEF,
  parameter int DIV_W      = baud_pkg::DIV_W_DEF,
  parameter int DIV_LSB    = baud_pkg::DIV_LSB_DEF,
  parameter int OS_PER_BIT = baud_pkg::OS_PER_BIT_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  output logic              busy,
  output logic              os_tick,
  output logic              bit_tick
);
  logic [PRE_W-1:0] act_pre;
  logic [DIV_W-1:0] act_div;
  logic             pre_fire;
  logic             os_fire;
  logic             bit_fire;

  baud_cfg_reg #(
    .CTRL_W (CTRL_W),
    .PRE_W  (PRE_W),
    .PRE_LSB(PRE_LSB),
    .DIV_W  (DIV_W),
    .DIV_LSB(DIV_LSB)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .boundary(bit_fire),
    .act_pre (act_pre),
    .act_div (act_div),
    .busy    (busy),
    .rd_data (rd_data)
  );

  baud_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .ratio_m1(act_pre),
    .fire    (pre_fire)
  );

  baud_fine_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .step   (pre_fire),
    .div_m1 (act_div),
    .os_fire(os_fire),
    .os_tick(os_tick)
  );

  baud_bit_count #(.OS_PER_BIT(OS_PER_BIT)) u_bit (
    .clk     (clk),
    .rst     (rst),
    .os_fire (os_fire),
    .bit_fire(bit_fire),
    .bit_tick(bit_tick)
  );

  // R4
  a_r4_bit_on_os: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> os_tick);

  // R6
  a_r6_busy_falls_on_bit: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> bit_tick);

endmodule

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;
  localparam logic [31:0] MASK = 32'h000F_03FF;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        busy, os_tick, bit_tick;

  always #2.5 clk = ~clk;

  baud_tick_gen uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .busy(busy), .os_tick(os_tick), .bit_tick(bit_tick)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  int os_q[$];
  int bit_q[$];
  int os_last = 0, bit_last = 0, arm_cyc = 0;
  bit armed = 1'b0;
  bit done  = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: compares measured spacings against the queued expectations
  always @(negedge clk) begin
    int e;
    if (!rst) begin
      if (bit_tick) check(os_tick, "R4 bit_tick coincides with os_tick", os_tick, 1);
      if (armed && cyc > arm_cyc) begin
        if (os_tick) begin
          if (os_q.size() > 0) begin
            e = os_q.pop_front();
            check(cyc - os_last == e, "R3 os_tick spacing", cyc - os_last, e);
          end
          os_last = cyc;
        end
        if (bit_tick) begin
          if (bit_q.size() > 0) begin
            e = bit_q.pop_front();
            check(cyc - bit_last == e, "R4 bit_tick spacing", cyc - bit_last, e);
          end
          bit_last = cyc;
        end
      end
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    check(busy == 1'b1, "R5 busy after write", busy, 1);
    check(rd_data == (d & MASK), "R2 readback masked", rd_data, d & MASK);
  endtask

  task automatic wait_update(input int old_per);
    int last = -1;
    int n = 0;
    armed = 1'b0;
    while (busy && n < 40000) begin
      @(negedge clk);
      n++;
      if (busy && os_tick) begin
        if (last >= 0)
          check(cyc - last == old_per, "R6 old spacing kept while pending", cyc - last, old_per);
        last = cyc;
      end
    end
    check(!busy, "R6 pending setting reached a boundary", busy, 0);
    check(bit_tick == 1'b1, "R6 busy falls with bit_tick", bit_tick, 1);
  endtask

  task automatic measure(input int p, input int d, input int n_os, input int n_bit);
    int per = (p + 1) * (d + 1);
    int g = 0;
    for (int i = 0; i < n_os; i++)  os_q.push_back(per);
    for (int i = 0; i < n_bit; i++) bit_q.push_back(13 * per);
    os_last  = cyc;
    bit_last = cyc;
    arm_cyc  = cyc;
    armed    = 1'b1;
    while ((os_q.size() > 0 || bit_q.size() > 0) && g < 60000) begin
      @(negedge clk);
      g++;
    end
    check(os_q.size() == 0 && bit_q.size() == 0, "R3 measurement completed",
          os_q.size() + bit_q.size(), 0);
    armed = 1'b0;
  endtask

  function automatic logic [31:0] word(input int p, input int d);
    return (32'(p) << 16) | 32'(d);
  endfunction

  task automatic setting(input int p, input int d, input int n_os, input int n_bit,
                         input int old_per);
    wr(word(p, d));
    wait_update(old_per);
    measure(p, d, n_os, n_bit);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 / R4: reset state and first bit boundary
    for (int i = 1; i <= 13; i++) begin
      @(negedge clk);
      if (i == 1) begin
        check(rd_data == 32'h0, "R1 control word cleared", rd_data, 0);
        check(busy == 1'b0, "R1 busy cleared", busy, 0);
      end
      check(os_tick == 1'b1, "R1 divide-by-one tick every cycle", os_tick, 1);
      check(bit_tick == (i == 13), "R4 first bit_tick on cycle 13", bit_tick, i == 13);
    end

    setting(1, 0, 10, 2, 1);
    setting(3, 2, 6, 2, 2);

    // R7: overwrite a pending word right after a bit boundary
    wr(word(5, 5));
    wr(word(0, 4));
    wait_update(12);
    check(rd_data == word(0, 4), "R7 latest write wins", rd_data, word(0, 4));
    measure(0, 4, 6, 2);

    setting(15, 0, 4, 2, 5);
    setting(2, 9, 4, 1, 16);
    setting(0, 0, 8, 2, 30);
    setting(0, 1023, 2, 1, 1);

    wr(32'hA5A5_5A5A);  // R2: bits outside the fields read back as zero

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    while (cyc < WATCHDOG && !done) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule